// File: doc/BRIEF.md
# GF(2) Quadratic Term Accumulator

This block computes the quadratic part of one polynomial over GF(2): the exclusive-OR, over every pair of state bits, of the pair product weighted by its coefficient bit. An upstream unit produces 128 pair products per cycle, and a coefficient store supplies the matching 128 coefficient bits. The block masks each product with its coefficient and reduces the masked word to one bit. That bit is folded into a running accumulator. One polynomial is normally spread over 64 such words, and the final word carries a last flag.

The reduction is shaped for 6-input lookup tables and is pipelined. First, 42 leaf groups of three masked products and one group of two produce 43 bits, which are registered. Next, seven 6-input XOR nodes reduce the first 42 of those bits, and the odd 43rd bit passes through beside them. These bits are also registered. Finally, one 9-input XOR combines the seven node bits, the odd bit and the running accumulator bit. A result appears two clock cycles after the edge that accepts the last word. Evaluations can follow each other with no gap. A clear input discards any partial evaluation.

Top module: `gf2_quad_accum`

## Requirements
- R1: While reset is asserted and right after it, `res_vld` is 0 and `res_bit` is 0.
- R2: The bit presented with `res_vld` equals the XOR, over every word accepted since the evaluation began, of the parity of `prod & coef`. A word is accepted when `in_vld` is 1 and `clr` is 0.
- R3: `res_vld` is 1 for exactly the cycle that follows the second rising edge after the edge that accepts a word with `in_last` = 1. It is never 1 at any other time, as long as no clear intervenes.
- R4: A cycle with `in_vld` = 0 has no effect on the result, on its timing or on `res_vld`, whatever `prod`, `coef` and `in_last` carry.
- R5: When `clr` is 1 at a rising edge, the accumulator becomes 0 at that edge. Any word presented in that cycle is dropped, and so is every word still in flight, so no result is produced for them.
- R6: The first word accepted after a last word starts a new evaluation from zero. Back-to-back evaluations need no clear between them.
- R7: `res_bit` changes only at an edge where an accepted word reaches the final stage, or at an edge where `clr` is 1. Between evaluations it holds the last result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| clr | input | 1 | Discard the partial evaluation and zero the accumulator |
| in_vld | input | 1 | The word on `prod`/`coef` is valid this cycle |
| in_last | input | 1 | The valid word is the final round of its evaluation |
| prod | input | 128 | Pair products of state bits for this round |
| coef | input | 128 | Coefficient bits matching `prod` position by position |
| res_bit | output | 1 | Accumulated quadratic sum; the result when `res_vld` is 1 |
| res_vld | output | 1 | One-cycle pulse marking a finished evaluation |

## Verification
The assertions check the timing rules on every cycle. A result pulse must trace back to a last word accepted three sampling ticks earlier, with no clear in between. A clear must leave the outputs at zero. The result bit may move only when a clear or an accepted word explains the change. The value of the sum can be shown only by the bench's scenarios, because it comes from a model of the masked parities. Those scenarios cover a full 64-round evaluation, all-zero and all-one coefficients, invalid cycles carrying garbage, a clear in the middle of an evaluation, a last word cancelled in flight, and two evaluations back to back.

// File: rtl/gqa_pkg.sv
package gqa_pkg;
  // Number of groups of size b needed to cover a items.
  function automatic int ceil_div(input int a, input int b);
    return (a + b - 1) / b;
  endfunction
endpackage

// File: rtl/gqa_leaf_stage.sv
// Stage 1: mask products with coefficients, XOR each leaf group, register.
module gqa_leaf_stage #(
  parameter int WIDTH = 128,
  parameter int LEAF  = 3,
  parameter int N_L1  = 43
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             in_vld,
  input  logic             in_last,
  input  logic [WIDTH-1:0] prod,
  input  logic [WIDTH-1:0] coef,
  output logic [N_L1-1:0]  l1_q,
  output logic             l1_vld,
  output logic             l1_last
);
  logic [WIDTH-1:0] term;
  logic [N_L1-1:0]  l1_d;
  logic             load;

  assign term = prod & coef;

  for (genvar g = 0; g < N_L1; g++) begin : g_leaf
    localparam int LO = g * LEAF;
    localparam int HI = (LO + LEAF - 1 > WIDTH - 1) ? WIDTH - 1 : LO + LEAF - 1;
    assign l1_d[g] = ^term[HI:LO];
  end

  always_comb begin
    load = in_vld & ~clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l1_q    <= '0;
      l1_vld  <= 1'b0;
      l1_last <= 1'b0;
    end else begin
      l1_vld <= load;
      if (load) begin
        l1_q    <= l1_d;
        l1_last <= in_last;
      end
    end
  end
endmodule

// File: rtl/gqa_node_stage.sv
// Stage 2: reduce full leaf bits in NODE-wide XORs, pass the odd tail, register.
module gqa_node_stage #(
  parameter int N_L1   = 43,
  parameter int N_FULL = 42,
  parameter int NODE   = 6,
  parameter int N_NODE = 7,
  parameter int N_TAIL = 1,
  parameter int N_L2   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic [N_L1-1:0] l1_q,
  input  logic            l1_vld,
  input  logic            l1_last,
  output logic [N_L2-1:0] l2_q,
  output logic            l2_vld,
  output logic            l2_last
);
  logic [N_L2-1:0] l2_d;
  logic            load;

  for (genvar n = 0; n < N_NODE; n++) begin : g_node
    localparam int LO = n * NODE;
    localparam int HI = (LO + NODE - 1 > N_FULL - 1) ? N_FULL - 1 : LO + NODE - 1;
    assign l2_d[n] = ^l1_q[HI:LO];
  end

  if (N_TAIL > 0) begin : g_tail
    assign l2_d[N_L2-1:N_NODE] = l1_q[N_L1-1:N_FULL];
  end

  always_comb begin
    load = l1_vld & ~clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l2_q    <= '0;
      l2_vld  <= 1'b0;
      l2_last <= 1'b0;
    end else begin
      l2_vld <= load;
      if (load) begin
        l2_q    <= l2_d;
        l2_last <= l1_last;
      end
    end
  end
endmodule

// File: rtl/gqa_fold_stage.sv
// Stage 3: wide XOR of node bits with the running accumulator.
module gqa_fold_stage #(
  parameter int N_L2 = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic [N_L2-1:0] l2_q,
  input  logic            l2_vld,
  input  logic            l2_last,
  output logic            res_bit,
  output logic            res_vld
);
  logic acc_q, acc_d;
  logic fresh_q, fresh_d;
  logic vld_q, vld_d;
  logic base;

  always_comb begin
    base    = fresh_q ? 1'b0 : acc_q;
    acc_d   = acc_q;
    fresh_d = fresh_q;
    vld_d   = 1'b0;
    if (clr) begin
      acc_d   = 1'b0;
      fresh_d = 1'b1;
    end else if (l2_vld) begin
      acc_d   = (^l2_q) ^ base;
      fresh_d = l2_last;
      vld_d   = l2_last;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= 1'b0;
      fresh_q <= 1'b1;
      vld_q   <= 1'b0;
    end else begin
      acc_q   <= acc_d;
      fresh_q <= fresh_d;
      vld_q   <= vld_d;
    end
  end

  assign res_bit = acc_q;
  assign res_vld = vld_q;
endmodule

// File: rtl/gf2_quad_accum.sv
module gf2_quad_accum #(
  parameter int WIDTH = 128,
  parameter int LEAF  = 3,
  parameter int NODE  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             in_vld,
  input  logic             in_last,
  input  logic [WIDTH-1:0] prod,
  input  logic [WIDTH-1:0] coef,
  output logic             res_bit,
  output logic             res_vld
);
  localparam int N_FULL = WIDTH / LEAF;
  localparam int N_L1   = gqa_pkg::ceil_div(WIDTH, LEAF);
  localparam int N_TAIL = N_L1 - N_FULL;
  localparam int N_NODE = gqa_pkg::ceil_div(N_FULL, NODE);
  localparam int N_L2   = N_NODE + N_TAIL;

  logic [N_L1-1:0] l1_q;
  logic            l1_vld, l1_last;
  logic [N_L2-1:0] l2_q;
  logic            l2_vld, l2_last;

  gqa_leaf_stage #(.WIDTH(WIDTH), .LEAF(LEAF), .N_L1(N_L1)) leaf_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_vld(in_vld), .in_last(in_last),
    .prod(prod), .coef(coef), .l1_q(l1_q), .l1_vld(l1_vld), .l1_last(l1_last)
  );

  gqa_node_stage #(
    .N_L1(N_L1), .N_FULL(N_FULL), .NODE(NODE),
    .N_NODE(N_NODE), .N_TAIL(N_TAIL), .N_L2(N_L2)
  ) node_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .l1_q(l1_q), .l1_vld(l1_vld),
    .l1_last(l1_last), .l2_q(l2_q), .l2_vld(l2_vld), .l2_last(l2_last)
  );

  gqa_fold_stage #(.N_L2(N_L2)) fold_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .l2_q(l2_q), .l2_vld(l2_vld),
    .l2_last(l2_last), .res_bit(res_bit), .res_vld(res_vld)
  );
endmodule

// File: rtl/gqa_checker.sv
module gqa_checker (
  input logic clk,
  input logic rst_n,
  input logic clr,
  input logic in_vld,
  input logic in_last,
  input logic res_bit,
  input logic res_vld
);
  // R1: outputs are quiet while reset is held.
  always_ff @(negedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (!res_vld && !res_bit)
        else $error("R1 outputs not zero in reset");
    end
  end

  // R3: a result pulse traces back to an accepted last word, no clear since.
  assert_result_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |-> ($past(in_vld && in_last, 3) && !$past(clr, 3)
                 && !$past(clr, 2) && !$past(clr, 1)))
    else $error("R3 result pulse without matching last word");

  // R5: a clear leaves both outputs at zero.
  assert_clear_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!res_vld && !res_bit))
    else $error("R5 outputs not zero after clear");

  // R7: the result bit moves only on a clear or an arriving accepted word.
  assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(res_bit) |-> ($past(clr, 1) || $past(in_vld, 3)))
    else $error("R7 result bit changed without cause");
endmodule

bind gf2_quad_accum gqa_checker chk_i (
  .clk(clk), .rst_n(rst_n), .clr(clr), .in_vld(in_vld), .in_last(in_last),
  .res_bit(res_bit), .res_vld(res_vld)
);

// File: tb/gf2_quad_accum_tb_top.sv
`timescale 1ns/1ps
module gf2_quad_accum_tb_top;
  localparam int W = 128;

  logic         clk;
  logic         rst_n;
  logic         clr;
  logic         in_vld;
  logic         in_last;
  logic [W-1:0] prod;
  logic [W-1:0] coef;
  logic         res_bit;
  logic         res_vld;

  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 0;
  logic model;

  gf2_quad_accum dut_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_vld(in_vld), .in_last(in_last),
    .prod(prod), .coef(coef), .res_bit(res_bit), .res_vld(res_vld)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [W-1:0] rnd();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  // Drive one accepted word; returns at the negedge after its edge.
  task automatic put(input logic [W-1:0] p, input logic [W-1:0] c, input logic last);
    prod = p; coef = c; in_vld = 1'b1; in_last = last;
    model = model ^ (^(p & c));
    step();
    in_vld = 1'b0; in_last = 1'b0;
  endtask

  // Invalid cycles carrying garbage and a raised last flag.
  task automatic idle(input int n, input string req, input bit check_vld);
    for (int i = 0; i < n; i++) begin
      prod = rnd(); coef = rnd(); in_vld = 1'b0; in_last = 1'b1;
      step();
      if (check_vld) chk(req, "res_vld during idle", res_vld, 1'b0);
    end
    in_last = 1'b0;
  endtask

  task automatic pulse_clr();
    prod = rnd(); coef = rnd(); clr = 1'b1; in_vld = 1'b1; in_last = 1'b1;
    step();
    clr = 1'b0; in_vld = 1'b0; in_last = 1'b0;
    model = 1'b0;
  endtask

  // Called right after the last word's edge.
  task automatic expect_result(input string req, input logic exp);
    chk("R3", "res_vld +0", res_vld, 1'b0);
    step();
    chk("R3", "res_vld +1", res_vld, 1'b0);
    step();
    chk("R3", "res_vld +2", res_vld, 1'b1);
    chk(req, "res_bit", res_bit, exp);
    step();
    chk("R3", "res_vld pulse end", res_vld, 1'b0);
    chk("R7", "res_bit held", res_bit, exp);
  endtask

  task automatic t_reset();
    chk("R1", "res_vld in reset", res_vld, 1'b0);
    chk("R1", "res_bit in reset", res_bit, 1'b0);
    rst_n = 1'b1;
    step();
    chk("R1", "res_vld after reset", res_vld, 1'b0);
    chk("R1", "res_bit after reset", res_bit, 1'b0);
  endtask

  task automatic t_full();
    pulse_clr();
    for (int r = 0; r < 64; r++) put(rnd(), rnd(), r == 63);
    expect_result("R2", model);
  endtask

  task automatic t_coef_edges();
    pulse_clr();
    put(rnd(), '0, 1'b0);
    put(rnd(), '0, 1'b1);
    expect_result("R2", 1'b0);
    pulse_clr();
    put(128'h1, '1, 1'b0);
    put(128'h3, '1, 1'b0);
    put({1'b1, 127'h0}, '1, 1'b1);
    expect_result("R2", 1'b0);
    pulse_clr();
    put(128'h5, 128'h4, 1'b1);
    expect_result("R2", 1'b1);
  endtask

  task automatic t_gaps();
    pulse_clr();
    for (int r = 0; r < 8; r++) begin
      put(rnd(), rnd(), r == 7);
      if (r != 7) idle(r % 3 + 1, "R4", 1'b1);
    end
    expect_result("R4", model);
  endtask

  task automatic t_clear();
    pulse_clr();
    for (int r = 0; r < 5; r++) put(rnd(), rnd(), 1'b0);
    pulse_clr();
    chk("R5", "res_bit after clear", res_bit, 1'b0);
    put(rnd(), rnd(), 1'b0);
    put(128'h7, 128'h1, 1'b0);
    put(rnd(), rnd(), 1'b1);
    expect_result("R5", model);
    // A last word cancelled while in flight produces no result.
    put(rnd(), rnd(), 1'b1);
    pulse_clr();
    for (int i = 0; i < 3; i++) begin
      chk("R5", "no result after cancel", res_vld, 1'b0);
      step();
    end
    chk("R5", "res_bit zero after cancel", res_bit, 1'b0);
  endtask

  task automatic t_b2b();
    logic a_res;
    pulse_clr();
    put(rnd(), rnd(), 1'b0);
    put(rnd(), rnd(), 1'b1);
    a_res = model;
    model = 1'b0;
    put(rnd(), rnd(), 1'b0);
    chk("R6", "res_vld before A result", res_vld, 1'b0);
    put(rnd(), rnd(), 1'b1);
    chk("R6", "A res_vld", res_vld, 1'b1);
    chk("R6", "A res_bit", res_bit, a_res);
    step();
    chk("R6", "gap res_vld", res_vld, 1'b0);
    step();
    chk("R6", "B res_vld", res_vld, 1'b1);
    chk("R6", "B res_bit fresh start", res_bit, model);
    step();
  endtask

  task automatic t_hold();
    pulse_clr();
    put(128'h1, 128'h1, 1'b1);
    expect_result("R7", 1'b1);
    idle(10, "R7", 1'b1);
    chk("R7", "res_bit held over idle", res_bit, 1'b1);
  endtask

  initial begin
    rst_n = 1'b0; clr = 1'b0; in_vld = 1'b0; in_last = 1'b0;
    prod = '0; coef = '0; model = 1'b0;
    step(); step();
    t_reset();
    t_full();
    t_coef_edges();
    t_gaps();
    t_clear();
    t_b2b();
    t_hold();
    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog all: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule